// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block gives a processor six 32-bit event counters that software configures and reads through a small register port. Each counter picks one line of an event pulse bus through its own select code and adds one for every clock cycle in which that line is high, provided counting is not frozen. Freezing can be global, can follow the privilege level (supervisor or user), or can follow a per-process mark input (mark high or mark low).

A counter reaches its condition when its most significant bit becomes 1, which is the same as reading negative as a signed value. Software presets a counter to 0x8000_0000 minus the wanted interval to get a condition after that many events. An enabled condition can set the global freeze bit so that every counter stops. It can also raise a one-cycle interrupt pulse. When the interrupt fires, the current instruction address is captured and the interrupt enable is cleared, so software must re-arm it.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset every counter reads 0, control word A reads 0x8000_0000 (global freeze set), control words B and C read 0, and irq_o is 0.
- R2: Register addresses are: 0 control A, 1 control B, 2 control C, 3 captured address (read only), 4 to 9 counters 1 to 6. A write takes effect at the clock edge where reg_we is high. reg_rdata shows the register addressed at the previous clock edge.
- R3: Select fields are counter 1 at A[12:6], counter 2 at A[5:0], counter 3 at B[31:27], counter 4 at B[26:22], counter 5 at B[21:17] and counter 6 at B[16:11]. Code c in 1..EV_W-1 selects evt_i[c]. Code 0 and codes of EV_W or more select nothing. An unfrozen counter adds exactly 1 for each cycle in which its selected line is high.
- R4: While A[31] (global freeze) is 1, no counter changes except by a register write.
- R5: A[30] freezes counting while priv_sup_i is 1, and A[29] freezes counting while priv_sup_i is 0.
- R6: A[28] freezes counting while mark_i is 1, and A[27] freezes counting while mark_i is 0. Counting resumes in the first cycle the freezing condition is gone.
- R7: A counter whose bit 31 is 1 raises a condition only if its enable is set. The enable is A[15] for counter 1 and A[14] for counters 2 to 6. Without its enable, a set bit 31 changes neither A nor irq_o.
- R8: When A[25] is 1 and an enabled condition is present at a clock edge, A[31] becomes 1 at that edge, and all counting stops from then on.
- R9: When A[26] is 1 and an enabled condition is present at a clock edge, irq_o is 1 for the following cycle only. At that edge A[26] is cleared and the captured address register takes the value of sample_addr_i.
- R10: Control word C stores and reads back any value and has no effect on counting, freezing or the interrupt.
- R11: A counter wraps from 0xFFFF_FFFF to 0. A register write to a counter takes priority over an event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_i | input | EV_W | Event pulse lines, one per event code |
| priv_sup_i | input | 1 | 1 when the processor is in supervisor state |
| mark_i | input | 1 | Process mark bit |
| sample_addr_i | input | 32 | Current instruction address |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest situation to reach from the ports is a counter crossing into bit 31 while the condition and freeze controls are in a chosen state. Counting from zero would take about two billion events. The stimulus therefore writes the counter to 0x7FFF_FFFF through the register port and sends a single event pulse. It then checks irq_o, the freeze bit and the captured address on the exact cycles after the crossing. The freeze gating is swept over all sixteen combinations of the four privilege and mark freeze bits, against all four states of the privilege and mark inputs.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int N_CTR  = 6;
  localparam int REG_W  = 32;
  localparam int SEL_MAX_W = 7;

  // control word A bit positions
  localparam int A_FRZ_ALL  = 31;
  localparam int A_FRZ_SUP  = 30;
  localparam int A_FRZ_USR  = 29;
  localparam int A_FRZ_MK1  = 28;
  localparam int A_FRZ_MK0  = 27;
  localparam int A_EXC_EN   = 26;
  localparam int A_FRZ_COND = 25;
  localparam int A_C1_EN    = 15;
  localparam int A_CN_EN    = 14;

  // register addresses
  localparam logic [3:0] ADR_CTLA = 4'd0;
  localparam logic [3:0] ADR_CTLB = 4'd1;
  localparam logic [3:0] ADR_CTLC = 4'd2;
  localparam logic [3:0] ADR_SAMP = 4'd3;
  localparam logic [3:0] ADR_CNT0 = 4'd4;

  typedef struct packed {
    logic sup;
    logic usr;
    logic mk1;
    logic mk0;
  } frz_mode_t;

  // Select code of counter idx (0-based) taken from the control words.
  function automatic logic [SEL_MAX_W-1:0] sel_code(input logic [REG_W-1:0] a,
                                                    input logic [REG_W-1:0] b,
                                                    input int idx);
    logic [SEL_MAX_W-1:0] c;
    c = '0;
    case (idx)
      0: c = a[12:6];
      1: c = {1'b0, a[5:0]};
      2: c = {2'b0, b[31:27]};
      3: c = {2'b0, b[26:22]};
      4: c = {2'b0, b[21:17]};
      default: c = {1'b0, b[16:11]};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pmu_gate.sv
module pmu_gate
  import pmu_pkg::*;
(
  input  logic      frz_all,
  input  frz_mode_t mode,
  input  logic      priv_sup_i,
  input  logic      mark_i,
  output logic      cnt_en
);
  logic blk_priv, blk_mark;

  always_comb begin
    blk_priv = (mode.sup & priv_sup_i) | (mode.usr & ~priv_sup_i);
    blk_mark = (mode.mk1 & mark_i) | (mode.mk0 & ~mark_i);
    cnt_en   = ~frz_all & ~blk_priv & ~blk_mark;
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W = 32,
  parameter int EV_W  = 32,
  parameter int SEL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [EV_W-1:0]  evt_i,
  input  logic             cnt_en,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int EXT_W = 1 << SEL_W;

  logic [EXT_W-1:0] ev_ext;
  logic             hit;

  always_comb begin
    ev_ext = '0;
    ev_ext[EV_W-1:0] = evt_i;
    hit = (sel != '0) && ev_ext[sel];
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (wr_en)
      cnt_q <= wr_data;
    else if (cnt_en && hit)
      cnt_q <= cnt_q + 1'b1;
  end

  // R4: a gated counter holds its value unless written
  a_r4_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !wr_en) |=> $stable(cnt_q));

  // R11: without a write, a counter moves by at most one per cycle
  a_r11_single_step: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pmu_ctl.sv
module pmu_ctl
  import pmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic             wr_c,
  input  logic [REG_W-1:0] wdata,
  input  logic             cond_any,
  input  logic [REG_W-1:0] sample_addr_i,
  output logic [REG_W-1:0] ctl_a_q,
  output logic [REG_W-1:0] ctl_b_q,
  output logic [REG_W-1:0] ctl_c_q,
  output logic [REG_W-1:0] samp_q,
  output logic             irq_o
);
  logic             fire;
  logic [REG_W-1:0] ctl_a_d;

  always_comb begin
    fire    = cond_any & ctl_a_q[A_EXC_EN];
    ctl_a_d = wr_a ? wdata : ctl_a_q;
    // hardware updates win over a same-cycle software write
    if (cond_any && ctl_a_q[A_FRZ_COND]) ctl_a_d[A_FRZ_ALL] = 1'b1;
    if (fire) ctl_a_d[A_EXC_EN] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_a_q <= REG_W'(1) << A_FRZ_ALL;
      ctl_b_q <= '0;
      ctl_c_q <= '0;
      samp_q  <= '0;
      irq_o   <= 1'b0;
    end else begin
      ctl_a_q <= ctl_a_d;
      if (wr_b) ctl_b_q <= wdata;
      if (wr_c) ctl_c_q <= wdata;
      if (fire) samp_q <= sample_addr_i;
      irq_o <= fire;
    end
  end

  // R8: an enabled condition with freeze-on-condition sets the global freeze
  a_r8_freeze_on_cond: assert property (@(posedge clk) disable iff (rst)
    (cond_any && ctl_a_q[A_FRZ_COND]) |=> ctl_a_q[A_FRZ_ALL]);

  // R9: the interrupt disarms its own enable
  a_r9_disarm: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !ctl_a_q[A_EXC_EN]);

  // R9: the captured address is the one present at the firing edge
  a_r9_capture: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> samp_q == $past(sample_addr_i));

  // R9: the interrupt lasts a single cycle unless re-armed
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !wr_a) |=> !irq_o);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int EV_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       reg_addr,
  input  logic             reg_we,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [EV_W-1:0]  evt_i,
  input  logic             priv_sup_i,
  input  logic             mark_i,
  input  logic [31:0]      sample_addr_i,
  output logic             irq_o
);
  localparam int MSB = REG_W - 1;

  logic [REG_W-1:0] ctl_a, ctl_b, ctl_c, samp;
  logic [REG_W-1:0] cnt [N_CTR];
  logic [N_CTR-1:0] cond;
  logic             cond_any, cnt_en;
  frz_mode_t        mode;

  always_comb begin
    mode.sup = ctl_a[A_FRZ_SUP];
    mode.usr = ctl_a[A_FRZ_USR];
    mode.mk1 = ctl_a[A_FRZ_MK1];
    mode.mk0 = ctl_a[A_FRZ_MK0];
  end

  pmu_gate u_gate (
    .frz_all    (ctl_a[A_FRZ_ALL]),
    .mode       (mode),
    .priv_sup_i (priv_sup_i),
    .mark_i     (mark_i),
    .cnt_en     (cnt_en)
  );

  pmu_ctl u_ctl (
    .clk           (clk),
    .rst           (rst),
    .wr_a          (reg_we && reg_addr == ADR_CTLA),
    .wr_b          (reg_we && reg_addr == ADR_CTLB),
    .wr_c          (reg_we && reg_addr == ADR_CTLC),
    .wdata         (reg_wdata),
    .cond_any      (cond_any),
    .sample_addr_i (sample_addr_i),
    .ctl_a_q       (ctl_a),
    .ctl_b_q       (ctl_b),
    .ctl_c_q       (ctl_c),
    .samp_q        (samp),
    .irq_o         (irq_o)
  );

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    localparam logic [3:0] MY_ADR = ADR_CNT0 + 4'(i);
    logic [SEL_MAX_W-1:0] sel;
    assign sel = sel_code(ctl_a, ctl_b, i);

    pmu_counter #(.CNT_W(REG_W), .EV_W(EV_W), .SEL_W(SEL_MAX_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .sel     (sel),
      .evt_i   (evt_i),
      .cnt_en  (cnt_en),
      .wr_en   (reg_we && reg_addr == MY_ADR),
      .wr_data (reg_wdata),
      .cnt_q   (cnt[i])
    );

    if (i == 0) begin : g_first
      assign cond[i] = cnt[i][MSB] & ctl_a[A_C1_EN];
    end else begin : g_rest
      assign cond[i] = cnt[i][MSB] & ctl_a[A_CN_EN];
    end
  end

  assign cond_any = |cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADR_CTLA: reg_rdata <= ctl_a;
        ADR_CTLB: reg_rdata <= ctl_b;
        ADR_CTLC: reg_rdata <= ctl_c;
        ADR_SAMP: reg_rdata <= samp;
        default: begin
          reg_rdata <= '0;
          for (int k = 0; k < N_CTR; k++)
            if (reg_addr == ADR_CNT0 + 4'(k)) reg_rdata <= cnt[k];
        end
      endcase
    end
  end

  // R7: the interrupt only follows an enabled condition
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(cond_any));

  // R1: no interrupt in the first cycle after reset
  a_r1_quiet_reset: assert property (@(posedge clk)
    $past(rst) |-> !irq_o);
endmodule

// File: tb/perf_mon_unit_tb.sv
module perf_mon_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt = '0;
  logic        priv = 1'b0;
  logic        mark = 1'b0;
  logic [31:0] saddr = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  perf_mon_unit u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt),
    .priv_sup_i(priv), .mark_i(mark), .sample_addr_i(saddr), .irq_o(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  // drive a bus pattern for n cycles, then clear it
  task automatic drive(input logic [31:0] v, input int n);
    @(negedge clk);
    evt = v;
    repeat (n) @(posedge clk);
    @(negedge clk);
    evt = '0;
  endtask

  logic [31:0] r;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(4'd0, r); chk("R1 ctlA", r, 32'h8000_0000);
    rd(4'd1, r); chk("R1 ctlB", r, 32'h0);
    rd(4'd2, r); chk("R1 ctlC", r, 32'h0);
    for (int i = 4; i < 10; i++) begin
      rd(4'(i), r); chk("R1 counter", r, 32'h0);
    end

    // R4 global freeze: select code 1, frozen
    wr(4'd0, 32'h8000_0000 | (32'd1 << 6));
    drive(32'h2, 4);
    rd(4'd4, r); chk("R4 frozen counter", r, 32'h0);

    // R3 sweep of counter 1 select codes, R2 read/write path
    for (int c = 0; c < 41; c++) begin
      logic [31:0] onehot;
      onehot = (c < 32) ? (32'd1 << c) : 32'd0;
      wr(4'd0, 32'(c) << 6);
      wr(4'd4, 32'h0);
      drive(onehot, 3);
      drive(~onehot, 2);
      rd(4'd4, r);
      chk("R3 counter1 code sweep", r, (c >= 1 && c < 32) ? 32'd3 : 32'd0);
    end
    rd(4'd0, r); chk("R2 ctlA readback", r, 32'd40 << 6);

    // R3 field positions of counters 2..6, each counting idx pulses
    wr(4'd0, 32'd9);             // counter 2 code 9
    wr(4'd1, 32'h0);
    wr(4'd5, 32'h0);
    drive(32'd1 << 9, 2);
    rd(4'd5, r); chk("R3 counter2 field", r, 32'd2);
    rd(4'd4, r); chk("R3 counter1 idle", r, 32'd0);
    wr(4'd0, 32'h0);
    for (int k = 3; k <= 6; k++) begin
      int code;
      logic [31:0] bw;
      code = 10 + k;
      case (k)
        3: bw = 32'(code) << 27;
        4: bw = 32'(code) << 22;
        5: bw = 32'(code) << 17;
        default: bw = 32'(code) << 11;
      endcase
      wr(4'd1, bw);
      wr(4'(k + 3), 32'h0);
      drive(32'd1 << code, k);
      rd(4'(k + 3), r); chk("R3 counter3-6 field", r, 32'(k));
    end
    wr(4'd1, 32'd40 << 11);      // counter 6 code 40 is beyond the bus
    wr(4'd9, 32'h0);
    drive(32'hFFFF_FFFF, 3);
    rd(4'd9, r); chk("R3 code beyond bus", r, 32'd0);
    wr(4'd1, 32'h0);

    // R5 R6 exhaustive freeze sweep on counter 1, code 1
    for (int f = 0; f < 16; f++) begin
      for (int s = 0; s < 4; s++) begin
        logic ps, mk, frozen;
        ps = s[1]; mk = s[0];
        frozen = (f[3] & ps) | (f[2] & ~ps) | (f[1] & mk) | (f[0] & ~mk);
        wr(4'd0, (32'(f) << 27) | (32'd1 << 6));
        wr(4'd4, 32'h0);
        @(negedge clk); priv = ps; mark = mk;
        drive(32'h2, 2);
        rd(4'd4, r);
        chk(f[1:0] != 0 ? "R6 mark freeze" : "R5 privilege freeze", r, frozen ? 32'd0 : 32'd2);
      end
    end
    @(negedge clk); priv = 1'b0; mark = 1'b0;

    // R6 resume once mark returns to 0
    wr(4'd0, (32'd1 << 28) | (32'd1 << 6));
    wr(4'd4, 32'h0);
    @(negedge clk); mark = 1'b1;
    drive(32'h2, 3);
    @(negedge clk); mark = 1'b0;
    drive(32'h2, 2);
    rd(4'd4, r); chk("R6 resume after mark", r, 32'd2);

    // R10 control C has no effect
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd4, 32'h0);
    drive(32'h2, 5);
    rd(4'd4, r); chk("R10 counting with C set", r, 32'd5);
    rd(4'd2, r); chk("R10 C readback", r, 32'hFFFF_FFFF);
    wr(4'd2, 32'h0);

    // R11 wrap and write priority
    wr(4'd4, 32'hFFFF_FFFF);
    drive(32'h2, 1);
    rd(4'd4, r); chk("R11 wrap", r, 32'h0);
    @(negedge clk); evt = 32'h2;
    wr(4'd4, 32'd100);
    @(negedge clk); evt = '0;
    // write edge: 100 (event ignored); next edge counts once more
    rd(4'd4, r); chk("R11 write priority", r, 32'd101);

    // R7 disabled condition: counter 4 crosses, only counter-1 enable set
    wr(4'd1, 32'd4 << 22);
    wr(4'd0, (32'd1 << 26) | (32'd1 << 15));
    wr(4'd7, 32'h7FFF_FFFF);
    drive(32'h10, 1);
    repeat (2) @(negedge clk);
    chk("R7 no irq when disabled", {31'b0, irq}, 32'h0);
    rd(4'd0, r); chk("R7 ctlA unchanged", r, 32'h0400_8000);
    rd(4'd7, r); chk("R7 counter crossed", r, 32'h8000_0000);
    wr(4'd7, 32'h0);

    // R8 freeze on condition: counter 3 with shared enable
    wr(4'd1, 32'd3 << 27);
    wr(4'd0, (32'd1 << 25) | (32'd1 << 14));
    wr(4'd6, 32'h7FFF_FFFF);
    drive(32'h8, 1);
    @(negedge clk);
    rd(4'd0, r); chk("R8 freeze set", r, 32'h8200_4000);
    drive(32'h8, 3);
    rd(4'd6, r); chk("R8 counting stopped", r, 32'h8000_0000);
    chk("R8 no irq", {31'b0, irq}, 32'h0);
    wr(4'd6, 32'h0);

    // R9 interrupt pulse and capture, counter 1
    saddr = 32'h1234_5678;
    wr(4'd1, 32'h0);
    wr(4'd0, (32'd1 << 26) | (32'd1 << 15) | (32'd1 << 6));
    wr(4'd4, 32'h7FFF_FFFF);
    drive(32'h2, 1);             // crossing at this edge
    chk("R9 irq not yet", {31'b0, irq}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R9 irq pulse", {31'b0, irq}, 32'h1);
    saddr = 32'hDEAD_0000;
    @(posedge clk); @(negedge clk);
    chk("R9 irq one cycle", {31'b0, irq}, 32'h0);
    rd(4'd3, r); chk("R9 captured address", r, 32'h1234_5678);
    rd(4'd0, r); chk("R9 enable cleared", r, (32'd1 << 15) | (32'd1 << 6));
    rd(4'd4, r); chk("R9 counter value", r, 32'h8000_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule